// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the read-path ECC checker of a memory controller and records the first error it reports. A read that fails its check raises a strobe together with a flag for the error class: correctable single-bit or uncorrectable multi-bit. The block then latches the upper bits of the failing address and the 8-bit syndrome into one 32-bit register. The record stays frozen until software clears the status, so the first fault is never overwritten by later ones.

The same register holds three control bits. One enables an NMI request on a logged corrected error. One enables a bus-error request on a logged uncorrectable error. One stops the scrub writeback that normally follows a corrected read. The two status bits are write-1-to-clear, and a clear only takes effect when both are written as 1 in the same write. A newly logged corrected error issues a one-cycle scrub request that carries the failing address aligned down to 8 KiB. The memory datapath uses that request to write back corrected data.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the register reads 0 and `nmi_req`, `buserr_req` and `scrub_req` are low.
- R2: A register write updates bit 31 (scrub disable), bit 3 (bus-error enable) and bit 2 (NMI enable) in the next cycle. Written values in bits 30:4 have no effect on the readback.
- R3: When the status is clear, a strobe with only the single-bit flag sets bit 0 in the next cycle. Bits 30:12 take `err_addr[31:13]` and bits 11:4 take `err_syn`.
- R4: When the status is clear, a strobe with the multi-bit flag sets bit 1 and captures the address and syndrome the same way as R3.
- R5: A strobe that carries both flags logs a multi-bit error: bit 1 is set and bit 0 stays 0.
- R6: While bit 0 or bit 1 is set, further strobes change neither status bit, the address field nor the syndrome field. The flag of the other class is never set.
- R7: Status is cleared only by a write with data bits 1:0 equal to 2'b11. A write with 2'b01, 2'b10 or 2'b00 there leaves both status bits unchanged.
- R8: A newly logged single-bit error asserts `scrub_req` for exactly one cycle, in the cycle after the strobe. In that cycle `scrub_addr` carries the failing address with bits 12:0 zero. If bit 31 is 1 when the strobe arrives, no scrub request is issued.
- R9: `nmi_req` is high exactly while bit 0 and bit 2 are both 1.
- R10: `buserr_req` is high exactly while bit 1 and bit 3 are both 1.
- R11: A strobe with neither flag set logs nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Error strobe from the read checker, one cycle per read |
| err_single | input | 1 | Strobe is a corrected single-bit error |
| err_multi | input | 1 | Strobe is an uncorrectable multi-bit error |
| err_addr | input | 32 | Address of the failing read |
| err_syn | input | 8 | Syndrome of the failing read |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback |
| nmi_req | output | 1 | NMI request level |
| buserr_req | output | 1 | Bus-error request level |
| scrub_req | output | 1 | One-cycle scrub writeback request |
| scrub_addr | output | 32 | Aligned address for the scrub request |

## Verification
The bench targets four kinds of mistake:
- A strobe that arrives while a record is held. A design that relogs here would overwrite the first error's address or set the second status flag.
- A clear that names only one status bit. A design that accepts it would let the next error in early.
- A strobe that carries both flags. A design that gets this wrong would log it as corrected and issue a scrub.
- The scrub request itself. It is checked for a pulse that lasts longer than one cycle, for a pulse issued while scrub is disabled, and for an address whose low bits are not dropped.

A long stretch of random strobes and writes, compared against the model on every clock, catches mistakes in how status clears and new errors interleave.

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
module ecc_err_log #(
  parameter int ADDR_W = 32,
  parameter int DROP_W = 13,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic              err_single,
  input  logic              err_multi,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              nmi_req,
  output logic              buserr_req,
  output logic              scrub_req,
  output logic [ADDR_W-1:0] scrub_addr
);
  localparam int KEEP_W = ADDR_W - DROP_W;
  localparam int SYN_LO = 4;
  localparam int ADR_LO = SYN_LO + SYN_W;
  localparam int DIS_B  = ADR_LO + KEEP_W;

  logic              st_sbe, st_mbe;
  logic              en_nmi, en_bus, scrub_dis;
  logic [KEEP_W-1:0] log_addr;
  logic [SYN_W-1:0]  log_syn;

  wire held    = st_sbe | st_mbe;
  wire take    = ~held & err_valid & (err_single | err_multi);
  wire clr_req = reg_wr & (&reg_wdata[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_sbe     <= 1'b0;
      st_mbe     <= 1'b0;
      log_addr   <= '0;
      log_syn    <= '0;
      scrub_req  <= 1'b0;
      scrub_addr <= '0;
    end else begin
      scrub_req <= take & err_single & ~err_multi & ~scrub_dis;
      if (take) begin
        st_mbe     <= err_multi;
        st_sbe     <= ~err_multi;
        log_addr   <= err_addr[ADDR_W-1:DROP_W];
        log_syn    <= err_syn;
        scrub_addr <= {err_addr[ADDR_W-1:DROP_W], {DROP_W{1'b0}}};
      end else if (clr_req) begin
        st_sbe <= 1'b0;
        st_mbe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_dis <= 1'b0;
      en_bus    <= 1'b0;
      en_nmi    <= 1'b0;
    end else if (reg_wr) begin
      scrub_dis <= reg_wdata[DIS_B];
      en_bus    <= reg_wdata[3];
      en_nmi    <= reg_wdata[2];
    end
  end

  assign reg_rdata  = {scrub_dis, log_addr, log_syn, en_bus, en_nmi, st_mbe, st_sbe};
  assign nmi_req    = st_sbe & en_nmi;
  assign buserr_req = st_mbe & en_bus;
endmodule

// File: rtl/ecc_err_log_chk.sv
`timescale 1ns/1ps
module ecc_err_log_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        err_valid,
  input logic        err_single,
  input logic        err_multi,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        nmi_req,
  input logic        buserr_req,
  input logic        scrub_req
);
  assert_one_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_rdata[1:0]));

  assert_record_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] != 2'b00 && !(reg_wr && reg_wdata[1:0] == 2'b11))
    |=> ($stable(reg_rdata[30:4]) && $stable(reg_rdata[1:0])));

  assert_partial_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] != 2'b00 && reg_wr && reg_wdata[1:0] != 2'b11)
    |=> $stable(reg_rdata[1:0]));

  assert_single_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[0]) |-> $past(err_valid && err_single && !err_multi));

  assert_scrub_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |=> !scrub_req);

  assert_scrub_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> (reg_rdata[0] && !$past(reg_rdata[31])));

  assert_nmi_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (reg_rdata[0] && reg_rdata[2]));

  assert_bus_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buserr_req |-> (reg_rdata[1] && reg_rdata[3]));
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_single(err_single),
  .err_multi(err_multi), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .nmi_req(nmi_req), .buserr_req(buserr_req),
  .scrub_req(scrub_req)
);

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0, err_single = 1'b0, err_multi = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0]  err_syn = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, scrub_addr;
  logic        nmi_req, buserr_req, scrub_req;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_sbe, m_mbe, m_sdis, m_ben, m_nen, m_scrub;
  longint m_addr, m_syn, m_saddr;

  always #4 clk = ~clk;

  ecc_err_log uut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_single(err_single),
    .err_multi(err_multi), .err_addr(err_addr), .err_syn(err_syn),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_req(nmi_req), .buserr_req(buserr_req), .scrub_req(scrub_req),
    .scrub_addr(scrub_addr)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sbe = 0; m_mbe = 0; m_sdis = 0; m_ben = 0; m_nen = 0; m_scrub = 0;
      m_addr = 0; m_syn = 0; m_saddr = 0;
    end else begin
      bit can;
      can = (m_sbe == 0 && m_mbe == 0) && err_valid && (err_single || err_multi);
      m_scrub = (can && err_single && !err_multi && m_sdis == 0) ? 1 : 0;
      if (can) begin
        m_mbe = err_multi ? 1 : 0;
        m_sbe = err_multi ? 0 : 1;
        m_addr = err_addr / 8192;
        m_syn = err_syn;
        m_saddr = (err_addr / 8192) * 8192;
      end else if (reg_wr && reg_wdata[1:0] == 2'b11) begin
        m_sbe = 0; m_mbe = 0;
      end
      if (reg_wr) begin
        m_sdis = reg_wdata[31]; m_ben = reg_wdata[3]; m_nen = reg_wdata[2];
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    longint exp_rd;
    exp_rd = (longint'(m_sdis) << 31) | (m_addr << 12) | (m_syn << 4) |
             (m_ben << 3) | (m_nen << 2) | (m_mbe << 1) | m_sbe;
    chk({cur_req, " readback"}, reg_rdata, exp_rd);
    chk({cur_req, " nmi R9"}, nmi_req, m_sbe & m_nen);
    chk({cur_req, " buserr R10"}, buserr_req, m_mbe & m_ben);
    chk({cur_req, " scrub R8"}, scrub_req, m_scrub);
    if (m_scrub != 0) chk({cur_req, " scrub_addr R8"}, scrub_addr, m_saddr);
  end

  task automatic step(input bit v, input bit s, input bit m, input logic [31:0] a,
                      input logic [7:0] sy, input bit w, input logic [31:0] wd);
    @(posedge clk); #2;
    err_valid = v; err_single = s; err_multi = m; err_addr = a; err_syn = sy;
    reg_wr = w; reg_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 32'h0, 8'h0, 0, 32'h0);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #2;
    cur_req = "R1";
    chk("R1 reset readback", reg_rdata, 0);
    chk("R1 reset requests", {nmi_req, buserr_req, scrub_req}, 0);
    idle(2);

    cur_req = "R2";
    step(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    idle(1);
    #2 chk("R2 control readback", reg_rdata, 32'h8000_000C);
    step(0, 0, 0, 0, 0, 1, 32'h0000_0004);
    idle(1);

    cur_req = "R3";
    step(1, 1, 0, 32'h1234_5678, 8'h5A, 0, 0);
    idle(1);
    #2 chk("R3 single log", reg_rdata, {13'h0 | (32'h1234_5678 >> 13), 12'h0} | 32'h5A4 | 32'h5);
    chk("R9 nmi on single", nmi_req, 1);
    cur_req = "R6";
    step(1, 0, 1, 32'hFFFF_E000, 8'hC3, 0, 0);
    step(1, 1, 0, 32'hAAAA_AAAA, 8'h11, 0, 0);
    idle(1);
    #2 chk("R6 record frozen", reg_rdata[1:0], 2'b01);
    cur_req = "R7";
    step(0, 0, 0, 0, 0, 1, 32'h0000_0005);
    step(0, 0, 0, 0, 0, 1, 32'h0000_0006);
    step(0, 0, 0, 0, 0, 1, 32'h0000_0004);
    idle(1);
    #2 chk("R7 partial clear kept", reg_rdata[1:0], 2'b01);
    step(0, 0, 0, 0, 0, 1, 32'h0000_000B);
    idle(1);
    #2 chk("R7 full clear", reg_rdata[1:0], 2'b00);

    cur_req = "R4";
    step(1, 0, 1, 32'h8000_2000, 8'h3C, 0, 0);
    idle(1);
    #2 chk("R4 multi log", reg_rdata[1:0], 2'b10);
    chk("R10 buserr on multi", buserr_req, 1);
    step(0, 0, 0, 0, 0, 1, 32'h0000_0003);

    cur_req = "R5";
    step(1, 1, 1, 32'h0000_4321, 8'h77, 0, 0);
    idle(1);
    #2 chk("R5 both flags multi wins", reg_rdata[1:0], 2'b10);
    chk("R5 no scrub", scrub_req, 0);
    step(0, 0, 0, 0, 0, 1, 32'h0000_0003);

    cur_req = "R8";
    step(1, 1, 0, 32'h7654_3FFF, 8'h01, 0, 0);
    @(posedge clk); #2;
    chk("R8 scrub pulse", scrub_req, 1);
    chk("R8 scrub addr", scrub_addr, 32'h7654_2000);
    idle(1);
    #2 chk("R8 pulse ends", scrub_req, 0);
    step(0, 0, 0, 0, 0, 1, 32'h8000_0003);
    step(1, 1, 0, 32'h0BAD_0000, 8'h02, 0, 0);
    @(posedge clk); #2;
    chk("R8 scrub disabled", scrub_req, 0);
    step(0, 0, 0, 0, 0, 1, 32'h0000_0003);

    cur_req = "R11";
    step(1, 0, 0, 32'hDEAD_BEEF, 8'hEE, 0, 0);
    idle(1);
    #2 chk("R11 no flag ignored", reg_rdata[1:0], 2'b00);

    cur_req = "R6 random";
    for (int i = 0; i < 3000; i++) begin
      bit v, s, m, w;
      logic [31:0] wd;
      v = ($urandom % 3) == 0;
      s = $urandom % 2;
      m = ($urandom % 3) == 0;
      w = ($urandom % 6) == 0;
      wd = $urandom;
      step(v, s, m, $urandom, $urandom, w, wd);
    end
    idle(3);
    finish_run();
  end
endmodule